// File: doc/BRIEF.md
# Trigger input conditioner

This block prepares one external trigger line for the trigger channels of a readout system. The raw line first passes through a sampling flip-flop that keeps metastable values out of the logic. A run-length spike filter follows. It counts how many consecutive cycles the sampled line has been high, and it lets the level through only once that count is greater than a programmable threshold. A selectable delay line comes last. It can shift the filtered level by 0 to 15 cycles, so that lines with different cable or detector runtimes can be brought into phase.

A single 32-bit configuration word sets both the threshold and the delay, and it can be read back. The conditioned level leaves the block through an output flip-flop. The shortest path, with threshold 0 and delay 0, is three cycles. Each unit of threshold and each unit of delay adds one cycle to the rising edge. Only the delay adds to the falling edge. A pulse that survives the filter therefore comes out shorter than it went in, by the threshold.

Top module: `trig_input_conditioner`

## Requirements
- R1: After reset, `trig_out` is low and `cfg_rdata` reads all zero, which means threshold 0 and delay 0.
- R2: A write with `cfg_we` high stores `cfg_wdata[3:0]` as the spike threshold T and `cfg_wdata[7:4]` as the delay selection D. From the next cycle, `cfg_rdata[7:0]` returns those bits and `cfg_rdata[31:8]` reads zero. Without a write, `cfg_rdata` does not change.
- R3: With T=0 and D=0, an input that is high at one sampling edge makes `trig_out` high after the third edge, counting that edge as the first, and for exactly one cycle.
- R4: An input pulse that is high for L consecutive sampling edges, with 1 <= L <= T, never makes `trig_out` high.
- R5: An input pulse of L > T consecutive high edges makes `trig_out` high for exactly L-T consecutive cycles.
- R6: For a pulse that passes, `trig_out` rises after edge 3+T+D, counting the first edge at which the input is high as edge 1.
- R7: `trig_out` falls after edge L+3+D, which is D+2 edges after the first edge at which the input is sampled low again.
- R8: The run counter saturates instead of wrapping. With T=15, an input held high for more than 15 edges is passed, and it stays high for as long as the input stays high.
- R9: With D=0 the shift register is bypassed, and `trig_out` follows the filter output one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Raw external trigger level, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data: [3:0] threshold, [7:4] delay |
| cfg_rdata | output | 32 | Configuration read-back, upper 24 bits zero |
| trig_out | output | 1 | Conditioned trigger level |

## Verification
The conditioned output is due 3+T+D cycles after the first high sample and drops D+2 cycles after the first low sample. The bench drives each pulse from a quiet, flushed pipeline. It records `trig_out` at every falling clock edge over a fixed window and compares each recorded sample with a waveform it computes from T, D and L alone. Configuration read-back is sampled one cycle after each write. Every write is followed by enough idle cycles to empty the 15-stage delay line before the next pulse starts.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int unsigned CNT_W    = 4;
    localparam int unsigned DSEL_W   = 4;
    localparam int unsigned CFG_DW   = 32;

    localparam int unsigned CNT_MAX  = (1 << CNT_W) - 1;
    localparam int unsigned TAPS     = (1 << DSEL_W) - 1;
    localparam int unsigned CFG_USED = CNT_W + DSEL_W;

    typedef logic [CNT_W-1:0]  thr_t;
    typedef logic [DSEL_W-1:0] dsel_t;
    typedef logic [CNT_W:0]    run_ext_t;

    // packed order puts thr in the low nibble, dsel above it
    typedef struct packed {
        dsel_t dsel;
        thr_t  thr;
    } cfg_t;

    typedef enum logic {
        PATH_BYPASS = 1'b0,
        PATH_TAP    = 1'b1
    } dly_path_e;

    function automatic cfg_t cfg_unpack(input logic [CFG_USED-1:0] w);
        return cfg_t'(w);
    endfunction

    function automatic logic [CFG_DW-1:0] cfg_pack(input cfg_t c);
        return {{(CFG_DW-CFG_USED){1'b0}}, c};
    endfunction

    function automatic thr_t run_sat_inc(input thr_t c);
        return (c == thr_t'(CNT_MAX)) ? c : c + 1'b1;
    endfunction

    function automatic run_ext_t run_ext_inc(input thr_t c);
        return {1'b0, c} + run_ext_t'(1);
    endfunction

endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
    parameter int unsigned STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= '0;
                else     stg_q <= {stg_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tic_spike_filter.sv
module tic_spike_filter
    import tic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    input  thr_t thr,
    output logic pass_q
);
    thr_t     run_q;
    run_ext_t run_next_ext;

    // one-bit-wider next count so that a saturated run still beats thr=15
    assign run_next_ext = run_ext_inc(run_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            pass_q <= 1'b0;
        end else if (lvl_in) begin
            run_q  <= run_sat_inc(run_q);
            pass_q <= (run_next_ext > {1'b0, thr});
        end else begin
            run_q  <= '0;
            pass_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tic_delay_line.sv
module tic_delay_line
    import tic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    input  dsel_t sel,
    output logic  dout
);
    logic [TAPS-1:0] sr_q;
    dsel_t           tap_idx;
    dly_path_e       path;

    generate
        if (TAPS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= din;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) sr_q <= '0;
                else     sr_q <= {sr_q[TAPS-2:0], din};
            end
        end
    endgenerate

    assign path    = (sel == '0) ? PATH_BYPASS : PATH_TAP;
    assign tap_idx = sel - 1'b1;

    always_comb begin
        unique case (path)
            PATH_BYPASS: dout = din;
            PATH_TAP:    dout = sr_q[tap_idx];
            default:     dout = din;
        endcase
    end
endmodule

// File: rtl/tic_cfg_reg.sv
module tic_cfg_reg
    import tic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_USED-1:0]  wbits,
    output cfg_t                 cfg_q,
    output logic [CFG_DW-1:0]    rdata
);
    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= '0;
        else if (we) cfg_q <= cfg_unpack(wbits);
    end

    assign rdata = cfg_pack(cfg_q);
endmodule

// File: rtl/trig_input_conditioner.sv
module trig_input_conditioner
    import tic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              trig_out
);
    logic sync_q;
    logic pass_q;
    logic dly_out;
    cfg_t cfg_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[CFG_DW-1:CFG_USED];

    tic_cfg_reg i_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wbits (cfg_wdata[CFG_USED-1:0]),
        .cfg_q (cfg_q),
        .rdata (cfg_rdata)
    );

    tic_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (trig_in),
        .q   (sync_q)
    );

    tic_spike_filter i_filt (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (sync_q),
        .thr    (cfg_q.thr),
        .pass_q (pass_q)
    );

    tic_delay_line i_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (pass_q),
        .sel  (cfg_q.dsel),
        .dout (dly_out)
    );

    always_ff @(posedge clk) begin
        if (rst) trig_out <= 1'b0;
        else     trig_out <= dly_out;
    end
endmodule

// File: rtl/tic_checker.sv
module tic_checker
    import tic_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        trig_out,
    input logic        sync_q,
    input logic        pass_q,
    input cfg_t        cfg_q
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!trig_out && cfg_rdata == '0));                      // R1

    AST_CFG_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[31:CFG_USED] == '0);                                        // R2

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[CFG_USED-1:0] == $past(cfg_wdata[CFG_USED-1:0])); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata));                                      // R2

    AST_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !sync_q |=> !pass_q);                                                 // R7

    AST_THR_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (sync_q && cfg_q.thr == '0) |=> pass_q);                              // R3

    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (pass_q && sync_q && $stable(cfg_q)) |=> pass_q);                     // R8

    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dsel == '0) |=> trig_out == $past(pass_q));                    // R9
endmodule

bind trig_input_conditioner tic_checker i_tic_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .trig_out  (trig_out),
    .sync_q    (sync_q),
    .pass_q    (pass_q),
    .cfg_q     (cfg_q)
);

// File: tb/test_trig_input_conditioner.sv
`timescale 1ns/100ps
module test_trig_input_conditioner;

    localparam int WIN = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        trig_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    trig_input_conditioner i_trig_input_conditioner (
        .clk       (clk),
        .rst       (rst),
        .trig_in   (trig_in),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .trig_out  (trig_out)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // expected: high for samples 3+T+D .. 2+D+L when L > T
    function automatic logic exp_out(input int t, input int d, input int l, input int i);
        return (l > t) && (i >= 3 + t + d) && (i < 3 + d + l);
    endfunction

    function automatic string sample_tag(input int t, input int d, input int l, input int i);
        if (l <= t)             return "R4";
        if (i == 3 + t + d)     return (d == 0) ? "R9" : "R6";
        if (i == 3 + d + l)     return "R7";
        return "R5";
    endfunction

    task automatic run_pulse(input int t, input int d, input int l, input string force_tag);
        logic obs [1:WIN];
        write_cfg({24'h0, 4'(d), 4'(t)});
        idle(40);
        trig_in = (l > 0);
        for (int i = 1; i <= WIN; i++) begin
            @(posedge clk);
            @(negedge clk);
            obs[i]  = trig_out;
            trig_in = (i < l);
        end
        for (int i = 1; i <= WIN; i++) begin
            string tg;
            tg = (force_tag.len() != 0) ? force_tag : sample_tag(t, d, l, i);
            check(tg, {31'h0, obs[i]}, {31'h0, exp_out(t, d, l, i)},
                  $sformatf("T=%0d D=%0d L=%0d sample %0d", t, d, l, i));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", {31'h0, trig_out}, 32'h0, "trig_out after reset");
        check("R1", cfg_rdata, 32'h0, "cfg_rdata after reset");

        // R2 configuration read-back
        write_cfg(32'hFFFF_FFFF);
        check("R2", cfg_rdata, 32'h0000_00FF, "readback all-ones");
        write_cfg(32'h1234_5678);
        check("R2", cfg_rdata, 32'h0000_0078, "readback pattern");
        idle(5);
        check("R2", cfg_rdata, 32'h0000_0078, "readback held");
        write_cfg(32'h0000_00A5);
        check("R2", cfg_rdata, 32'h0000_00A5, "readback A5");

        // R3 minimum latency, one-cycle input
        run_pulse(0, 0, 1, "R3");

        // R8 saturation: threshold 15, long and just-long-enough pulses
        run_pulse(15, 0, 40, "R8");
        run_pulse(15, 3, 16, "R8");

        // R4..R7, R9 sweep
        for (int t = 0; t < 16; t++) begin
            for (int di = 0; di < 4; di++) begin
                int d;
                d = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 7 : 15;
                run_pulse(t, d, 1, "");
                run_pulse(t, d, (t == 0) ? 2 : t, "");
                run_pulse(t, d, t + 1, "");
                run_pulse(t, d, t + 5, "");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule